// File: doc/BRIEF.md
# Two-Digit Time-Multiplexed Seven-Segment Driver

This block shows two 4-bit values on a seven-segment display with four digit positions. The segment lines are shared by all positions. A segment lights when its line is low. A position lights when its anode enable is high. Only one position can therefore show a value at any moment. The block alternates between the two values at a rate set by a parameter. The rate is chosen fast enough that the eye sees both digits lit at once.

A divider counts system clock cycles and flips a digit-select level every `DIV_COUNT` cycles. The select level picks one of the two nibbles. The picked nibble is turned into an active-low segment pattern. The select level and its inverse drive the two anode enables. The segment lines and the anode enables are loaded into the same output registers on the same edge. Because of this, a digit change never shows the old pattern on the new position. With a 50 MHz clock, the default `DIV_COUNT` of 25000 holds each digit for 0.5 ms. The two positions that are not used stay dark.

Top module: `dualDigitSegDriver`

## Requirements
- R1: While `rstN` is low, `anode` is all zeros and `segN` is 7'h7F (all segments dark).
- R2: After reset is released, each shown digit is held for exactly `DIV_COUNT` clock cycles before the other digit takes over. The first digit shown after reset is the low digit.
- R3: From the first clock edge after reset onward, exactly one of `anode[1:0]` is high. `anode[3:2]` stay low at all times.
- R4: When `anode` is 4'b0001, `segN` shows the pattern of `digitLo`. When `anode` is 4'b0010, it shows the pattern of `digitHi`. The value used is the one sampled on the clock edge that loaded the outputs.
- R5: `segN` bit i is segment a,b,c,d,e,f,g for i = 0..6, and a low bit lights the segment. In active-high form, hex codes 0..F give 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. `segN` is the bitwise inverse of these values.
- R6: `segN` and `anode` are registered. A change on a digit input appears on `segN` one clock edge later, never in the same cycle.
- R7: A change on the digit input that is not currently selected leaves `segN` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| digitLo | input | 4 | Value for the right-hand digit (anode 0) |
| digitHi | input | 4 | Value for the left-hand digit (anode 1) |
| segN | output | 7 | Shared segment lines g..a, active low |
| anode | output | 4 | Digit position enables, active high |

## Verification
The bench builds the block with `DIV_COUNT` set to 5. A full display cycle is therefore ten clock cycles, instead of tens of thousands. At that rate the following all fit in a few hundred cycles:
- many digit swaps;
- a sweep of all sixteen codes on both digits;
- directed checks that line a digit change up against the start of a display phase.

The dwell count is exact at 5, so a divider that is off by one cycle shows up on the first swap.

// File: rtl/segDrvPkg.sv
package segDrvPkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic showHigh;   // 1: high digit is selected for the next output load
  } ctrlStrobes_t;

  typedef logic [6:0] segPattern_t;  // bit0=a ... bit6=g

  // Active-high segment pattern for one hex code
  function automatic segPattern_t hexToSegHigh(input logic [3:0] code);
    segPattern_t p;
    case (code)
      4'h0: p = 7'h3F;
      4'h1: p = 7'h06;
      4'h2: p = 7'h5B;
      4'h3: p = 7'h4F;
      4'h4: p = 7'h66;
      4'h5: p = 7'h6D;
      4'h6: p = 7'h7D;
      4'h7: p = 7'h07;
      4'h8: p = 7'h7F;
      4'h9: p = 7'h6F;
      4'hA: p = 7'h77;
      4'hB: p = 7'h7C;
      4'hC: p = 7'h39;
      4'hD: p = 7'h5E;
      4'hE: p = 7'h79;
      default: p = 7'h71;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segDrvPkg::*;
#(
  parameter int DIV_COUNT = 25000
) (
  input  logic         clk,
  input  logic         rstN,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] divCnt;
  logic             selQ;
  logic             lastCycle;

  assign lastCycle = (divCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      selQ   <= 1'b0;
    end else if (lastCycle) begin
      divCnt <= '0;
      selQ   <= ~selQ;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign strobes.showHigh = selQ;

endmodule

// File: rtl/segDecoder.sv
module segDecoder
  import segDrvPkg::*;
(
  input  logic [3:0]  nibble,
  output segPattern_t segLow
);

  assign segLow = ~hexToSegHigh(nibble);

endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segDrvPkg::*;
#(
  parameter int ANODE_W = 4,
  parameter int NIB_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [NIB_W-1:0]   digitLo,
  input  logic [NIB_W-1:0]   digitHi,
  output logic [6:0]         segN,
  output logic [ANODE_W-1:0] anode
);

  logic [NIB_W-1:0]   pickedNibble;
  segPattern_t        segNext;
  logic [ANODE_W-1:0] anodeNext;

  assign pickedNibble = strobes.showHigh ? digitHi : digitLo;

  segDecoder uDecoder (
    .nibble (pickedNibble[3:0]),
    .segLow (segNext)
  );

  for (genvar i = 0; i < ANODE_W; i++) begin : gAnode
    if (i == 0) begin : gLo
      assign anodeNext[i] = ~strobes.showHigh;
    end else if (i == 1) begin : gHi
      assign anodeNext[i] = strobes.showHigh;
    end else begin : gOff
      assign anodeNext[i] = 1'b0;
    end
  end

  // Segments and anodes load on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segN  <= '1;
      anode <= '0;
    end else begin
      segN  <= segNext;
      anode <= anodeNext;
    end
  end

endmodule

// File: rtl/dualDigitSegDriver.sv
module dualDigitSegDriver
  import segDrvPkg::*;
#(
  parameter int DIV_COUNT = 25000,
  parameter int ANODE_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         digitLo,
  input  logic [3:0]         digitHi,
  output logic [6:0]         segN,
  output logic [ANODE_W-1:0] anode
);

  ctrlStrobes_t strobes;

  segCtrl #(.DIV_COUNT(DIV_COUNT)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  segDatapath #(.ANODE_W(ANODE_W), .NIB_W(4)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .digitLo (digitLo),
    .digitHi (digitHi),
    .segN    (segN),
    .anode   (anode)
  );

endmodule

// File: rtl/segDriverChecker.sv
module segDriverChecker #(
  parameter int DIV_COUNT = 25000,
  parameter int ANODE_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [3:0]         digitLo,
  input logic [3:0]         digitHi,
  input logic [6:0]         segN,
  input logic [ANODE_W-1:0] anode
);

  logic [ANODE_W-1:0] prevAnode;
  int unsigned        holdCnt;
  int unsigned        aliveCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAnode <= '0;
      holdCnt   <= 0;
      aliveCnt  <= 0;
    end else begin
      prevAnode <= anode;
      holdCnt   <= (anode != prevAnode) ? 1 : holdCnt + 1;
      if (aliveCnt < 8) aliveCnt <= aliveCnt + 1;
    end
  end

  // R2: a digit that gives way was held DIV_COUNT cycles
  assert_dwell_R2: assert property (@(posedge clk) disable iff (!rstN)
    (anode != prevAnode && prevAnode != '0) |-> holdCnt == DIV_COUNT);

  // R3: unused positions stay dark
  assert_unused_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    anode[ANODE_W-1:2] == '0);

  // R3: exactly one used position lit after the first edge
  assert_one_lit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (aliveCnt >= 1) |-> $countones(anode[1:0]) == 1);

  // R4/R7: steady selected digit gives steady segments
  assert_steady_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (aliveCnt >= 3 && anode[0] && $past(anode[0]) && $past(digitLo) == $past(digitLo, 2))
      |-> $stable(segN));

  assert_steady_hi_R7: assert property (@(posedge clk) disable iff (!rstN)
    (aliveCnt >= 3 && anode[1] && $past(anode[1]) && $past(digitHi) == $past(digitHi, 2))
      |-> $stable(segN));

endmodule

bind dualDigitSegDriver segDriverChecker #(.DIV_COUNT(DIV_COUNT), .ANODE_W(ANODE_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .digitLo (digitLo),
  .digitHi (digitHi),
  .segN    (segN),
  .anode   (anode)
);

// File: tb/tb_dualDigitSegDriver.sv
module tb_dualDigitSegDriver;

  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] digitLo = 4'h0;
  logic [3:0] digitHi = 4'h0;
  logic [6:0] segN;
  logic [3:0] anode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dualDigitSegDriver #(.DIV_COUNT(DIV), .ANODE_W(4)) dut (
    .clk(clk), .rstN(rstN), .digitLo(digitLo), .digitHi(digitHi),
    .segN(segN), .anode(anode)
  );

  function automatic logic [6:0] litPattern(input logic [3:0] c);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~t[c];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: which digit, how long it has been shown
  int         phaseLen = 0;
  bit         showingHi = 1'b0;
  logic [3:0] expAnode = 4'h0;
  logic [6:0] expSeg = 7'h7F;

  always @(posedge clk) begin
    if (!rstN) begin
      phaseLen  = 0;
      showingHi = 1'b0;
      expAnode  = 4'h0;
      expSeg    = 7'h7F;
    end else begin
      expAnode = showingHi ? 4'b0010 : 4'b0001;
      expSeg   = litPattern(showingHi ? digitHi : digitLo);
      phaseLen++;
      if (phaseLen == DIV) begin
        phaseLen  = 0;
        showingHi = !showingHi;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R2/R3 anode", anode, expAnode);
      check("R4/R5 segN", segN, expSeg);
    end
  end

  task automatic setDigits(input logic [3:0] lo, input logic [3:0] hi);
    @(posedge clk); #1;
    digitLo = lo;
    digitHi = hi;
  endtask

  initial begin
    // R1: reset state
    repeat (2) begin
      @(negedge clk);
      check("R1 anode", anode, 4'h0);
      check("R1 segN", segN, 7'h7F);
    end
    @(posedge clk); #1;
    rstN = 1'b1;

    // R2/R4: steady pair over several swaps
    setDigits(4'h3, 4'h7);
    repeat (30) @(posedge clk);

    // R5: all sixteen codes on both positions
    for (int i = 0; i < 16; i++) begin
      setDigits(4'(i), 4'(15 - i));
      repeat (2 * DIV) @(posedge clk);
    end

    // R7: change unselected high digit at start of low phase
    setDigits(4'h1, 4'h8);
    begin
      logic [3:0] prevA = 4'hF;
      bit found = 1'b0;
      while (!found) begin
        @(negedge clk);
        if (anode == 4'b0001 && prevA != 4'b0001) found = 1'b1;
        prevA = anode;
      end
    end
    @(posedge clk); #1;
    digitHi = 4'h6;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 segN unchanged", segN, litPattern(4'h1));
    end

    // R6: one edge of latency on a digit change
    setDigits(4'h2, 4'h2);
    repeat (3) @(posedge clk);
    #1;
    digitLo = 4'h9;
    digitHi = 4'h9;
    @(negedge clk);
    check("R6 old value held", segN, litPattern(4'h2));
    @(negedge clk);
    check("R6 new value after edge", segN, litPattern(4'h9));

    // R1: asynchronous reset mid-run
    @(posedge clk); #1;
    rstN = 1'b0;
    #1;
    check("R1 async anode", anode, 4'h0);
    check("R1 async segN", segN, 7'h7F);
    @(negedge clk);
    check("R1 held anode", anode, 4'h0);
    @(posedge clk); #1;
    rstN = 1'b1;
    setDigits(4'hA, 4'hC);
    repeat (25) @(posedge clk);

    done = 1'b1;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule